// File: doc/BRIEF.md
# Bus Error Status Logger

This block gathers error events seen on a processor's external bus and its interconnect. It records them in one 64-bit machine-check status word. Five sources feed it:

- a 3-bit response code that arrives with its own parity pin; the block checks that parity itself,
- an address-parity error strobe,
- a retirement watchdog timeout strobe,
- a hard-error response strobe,
- an internal-failure strobe.

Each source owns one status bit, and any logged event also raises the valid flag in the top bit.

Software sees the word through a plain port made of three parts: a registered read value, a write strobe with data, and a clear-all strobe. The fatal-class bits are the watchdog timeout, the hard error and the internal failure. Once set, these bits hold. No ordinary software write and no later error can alter them. Only clear-all releases them. The remaining defined bits are ordinary storage that software can write, with hardware setting the error bits on top. Reserved positions are tied to zero.

Top module: `bus_err_status_log`

## Requirements
- R1: When `rsp_valid` is high, bit 36 is set on the next clock edge if the XOR of `rsp_code[2:0]` and `rsp_par` is 1 (odd count of ones). An even count of ones sets nothing.
- R2: An `addr_par_err` pulse sets bit 37 on the next clock edge.
- R3: `wdog_timeout` sets bit 38, `hard_err_rsp` sets bit 42 and `int_err` sets bit 43, each on the next clock edge.
- R4: Once bit 38, 42 or 43 is set, it stays set until a clear-all. A software write cannot change it, whatever value the write carries for that bit.
- R5: A software write (`sw_wr_en`) loads bits 0 to 37 and bits 57 to 63 from `sw_wr_data` on the next clock edge, so bits 36, 37 and 63 can be cleared by writing zeros.
- R6: Bits 39 to 41 and bits 44 to 56 always read as zero and ignore writes.
- R7: Any error event (R1 to R3) also sets bit 63 on the same edge.
- R8: `sw_clear_all` zeroes the whole word on the next clock edge. It takes priority over error events and writes in the same cycle.
- R9: When an error event and a software write fall in the same cycle, the event's bit and bit 63 end up set, even if the write data holds zeros there.
- R10: Synchronous reset `rst` zeroes the word.
- R11: While `rsp_valid` is low, the response code and parity pin have no effect on the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsp_valid | input | 1 | Response code is present this cycle |
| rsp_code | input | 3 | Response code |
| rsp_par | input | 1 | Parity pin for the response code |
| addr_par_err | input | 1 | Address parity error strobe |
| wdog_timeout | input | 1 | Retirement watchdog timeout strobe |
| hard_err_rsp | input | 1 | Hard-error response strobe |
| int_err | input | 1 | Internal failure strobe |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 64 | Software write data |
| sw_clear_all | input | 1 | Software clear of the whole word |
| rd_data | output | 64 | Registered status word |

## Verification
The assertions assume that every input is a clean synchronous level sampled at each edge. They also assume that a strobe held for several cycles simply re-logs the same event each cycle, and that `rsp_code` and `rsp_par` matter only while `rsp_valid` is high. The random stimulus draws each strobe with low probability and keeps clear-all and writes rare. This lets sticky bits live across many writes. Bad parity is generated freely, both with and without `rsp_valid`, so that the qualification is exercised. Directed cases cover the priority collisions: event against write, and clear-all against event.

// File: rtl/bus_err_pkg.sv
package bus_err_pkg;
  localparam int STAT_W  = 64;
  localparam int RSP_W   = 3;

  localparam int B_RSP_PAR  = 36;
  localparam int B_ADDR_PAR = 37;
  localparam int B_WDOG     = 38;
  localparam int B_HARD     = 42;
  localparam int B_IERR     = 43;
  localparam int B_VALID    = 63;

  localparam int RSV_LO_A = 39;
  localparam int RSV_HI_A = 41;
  localparam int RSV_LO_B = 44;
  localparam int RSV_HI_B = 56;

  function automatic logic [STAT_W-1:0] range_mask(input int lo, input int hi);
    logic [STAT_W-1:0] m;
    m = '0;
    for (int i = lo; i <= hi; i++) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [STAT_W-1:0] STICKY_MASK =
    (STAT_W'(1) << B_WDOG) | (STAT_W'(1) << B_HARD) | (STAT_W'(1) << B_IERR);
  localparam logic [STAT_W-1:0] RSV_MASK =
    range_mask(RSV_LO_A, RSV_HI_A) | range_mask(RSV_LO_B, RSV_HI_B);

  typedef struct packed {
    logic rsp_par;
    logic addr_par;
    logic wdog;
    logic hard;
    logic ierr;
  } err_evt_t;
endpackage

// File: rtl/bus_err_parity_chk.sv
module bus_err_parity_chk #(
  parameter int CODE_W = 3
) (
  input  logic              rsp_valid,
  input  logic [CODE_W-1:0] rsp_code,
  input  logic              rsp_par,
  output logic              par_fail
);
  // Even parity over code plus parity pin; odd count flags a fault.
  always_comb par_fail = rsp_valid & (^{rsp_code, rsp_par});
endmodule

// File: rtl/bus_err_evt_map.sv
module bus_err_evt_map
  import bus_err_pkg::*;
#(
  parameter int W = STAT_W
) (
  input  err_evt_t     evt,
  output logic [W-1:0] set_vec
);
  logic any_evt;

  always_comb begin
    any_evt = evt.rsp_par | evt.addr_par | evt.wdog | evt.hard | evt.ierr;
    set_vec = '0;
    set_vec[B_RSP_PAR]  = evt.rsp_par;
    set_vec[B_ADDR_PAR] = evt.addr_par;
    set_vec[B_WDOG]     = evt.wdog;
    set_vec[B_HARD]     = evt.hard;
    set_vec[B_IERR]     = evt.ierr;
    set_vec[B_VALID]    = any_evt;
  end
endmodule

// File: rtl/bus_err_status_reg.sv
module bus_err_status_reg #(
  parameter int           W      = 64,
  parameter logic [W-1:0] STICKY = '0,
  parameter logic [W-1:0] RSV    = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_all,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] set_vec,
  output logic [W-1:0] stat_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (RSV[i]) begin : g_rsv
      assign stat_q[i] = 1'b0;
    end else if (STICKY[i]) begin : g_sticky
      logic q;
      always_ff @(posedge clk) begin
        if (rst || clear_all) q <= 1'b0;
        else if (set_vec[i])  q <= 1'b1;
      end
      assign stat_q[i] = q;
    end else begin : g_rw
      logic q;
      always_ff @(posedge clk) begin
        if (rst || clear_all) q <= 1'b0;
        else if (set_vec[i])  q <= 1'b1;
        else if (wr_en)       q <= wr_data[i];
      end
      assign stat_q[i] = q;
    end
  end
endmodule

// File: rtl/bus_err_status_log.sv
module bus_err_status_log
  import bus_err_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rsp_valid,
  input  logic [RSP_W-1:0]  rsp_code,
  input  logic              rsp_par,
  input  logic              addr_par_err,
  input  logic              wdog_timeout,
  input  logic              hard_err_rsp,
  input  logic              int_err,
  input  logic              sw_wr_en,
  input  logic [STAT_W-1:0] sw_wr_data,
  input  logic              sw_clear_all,
  output logic [STAT_W-1:0] rd_data
);
  logic              par_fail;
  err_evt_t          evt;
  logic [STAT_W-1:0] set_vec;

  bus_err_parity_chk #(.CODE_W(RSP_W)) u_par (
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code),
    .rsp_par   (rsp_par),
    .par_fail  (par_fail)
  );

  always_comb begin
    evt.rsp_par  = par_fail;
    evt.addr_par = addr_par_err;
    evt.wdog     = wdog_timeout;
    evt.hard     = hard_err_rsp;
    evt.ierr     = int_err;
  end

  bus_err_evt_map #(.W(STAT_W)) u_map (
    .evt     (evt),
    .set_vec (set_vec)
  );

  bus_err_status_reg #(
    .W      (STAT_W),
    .STICKY (STICKY_MASK),
    .RSV    (RSV_MASK)
  ) u_reg (
    .clk       (clk),
    .rst       (rst),
    .clear_all (sw_clear_all),
    .wr_en     (sw_wr_en),
    .wr_data   (sw_wr_data),
    .set_vec   (set_vec),
    .stat_q    (rd_data)
  );
endmodule

// File: rtl/bus_err_status_log_chk.sv
module bus_err_status_log_chk
  import bus_err_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              rsp_valid,
  input logic [RSP_W-1:0]  rsp_code,
  input logic              rsp_par,
  input logic              addr_par_err,
  input logic              wdog_timeout,
  input logic              hard_err_rsp,
  input logic              int_err,
  input logic              sw_wr_en,
  input logic [STAT_W-1:0] sw_wr_data,
  input logic              sw_clear_all,
  input logic [STAT_W-1:0] rd_data
);
  a_r1_rsp_parity: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (^{rsp_code, rsp_par}) && !sw_clear_all) |=> rd_data[B_RSP_PAR]);

  a_r2_addr_parity: assert property (@(posedge clk) disable iff (rst)
    (addr_par_err && !sw_clear_all) |=> rd_data[B_ADDR_PAR]);

  a_r4_wdog_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_data[B_WDOG] && !sw_clear_all) |=> rd_data[B_WDOG]);

  a_r4_hard_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_data[B_HARD] && !sw_clear_all) |=> rd_data[B_HARD]);

  a_r4_ierr_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_data[B_IERR] && !sw_clear_all) |=> rd_data[B_IERR]);

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    sw_wr_en |=> ((rd_data & RSV_MASK) == '0));

  a_r7_valid_on_event: assert property (@(posedge clk) disable iff (rst)
    ((addr_par_err || wdog_timeout || hard_err_rsp || int_err) && !sw_clear_all)
      |=> rd_data[B_VALID]);

  a_r8_clear_all: assert property (@(posedge clk) disable iff (rst)
    sw_clear_all |=> (rd_data == '0));

  a_r10_reset: assert property (@(posedge clk)
    rst |=> (rd_data == '0));
endmodule

bind bus_err_status_log bus_err_status_log_chk u_chk (.*);

// File: tb/bus_err_status_log_test.sv
`timescale 1ns/1ps
module bus_err_status_log_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rsp_valid = 0;
  logic [2:0]  rsp_code = 0;
  logic        rsp_par = 0;
  logic        addr_par_err = 0, wdog_timeout = 0, hard_err_rsp = 0, int_err = 0;
  logic        sw_wr_en = 0, sw_clear_all = 0;
  logic [63:0] sw_wr_data = 0;
  logic [63:0] rd_data;
  logic [63:0] exp_q = 0;
  int          n_chk = 0, n_fail = 0;

  // Field layout from the requirements.
  localparam logic [63:0] M_STICKY = (64'd1 << 38) | (64'd1 << 42) | (64'd1 << 43);
  localparam logic [63:0] M_RSV    = (64'h7 << 39) | (64'h1FFF << 44);
  localparam logic [63:0] M_WR     = ~(M_STICKY | M_RSV);

  always #4 clk = ~clk;

  bus_err_status_log uut (.*);

  function automatic logic [63:0] next_exp(input logic [63:0] cur);
    logic [63:0] n;
    logic pf;
    if (sw_clear_all) return 64'd0;
    n = cur;
    if (sw_wr_en) n = (cur & M_STICKY) | (sw_wr_data & M_WR);
    pf = rsp_valid && ((rsp_code[0] ^ rsp_code[1] ^ rsp_code[2] ^ rsp_par) == 1'b1);
    if (pf)           n[36] = 1'b1;
    if (addr_par_err) n[37] = 1'b1;
    if (wdog_timeout) n[38] = 1'b1;
    if (hard_err_rsp) n[42] = 1'b1;
    if (int_err)      n[43] = 1'b1;
    if (pf || addr_par_err || wdog_timeout || hard_err_rsp || int_err) n[63] = 1'b1;
    return n;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    rsp_valid = 0; rsp_code = 0; rsp_par = 0;
    addr_par_err = 0; wdog_timeout = 0; hard_err_rsp = 0; int_err = 0;
    sw_wr_en = 0; sw_wr_data = 0; sw_clear_all = 0;
  endtask

  // Advance one edge, update the model, compare after the edge.
  task automatic tick(input string tag);
    @(posedge clk);
    exp_q = next_exp(exp_q);
    #2;
    chk(tag, rd_data, exp_q);
    idle_inputs();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    chk("R10 reset", rd_data, 64'd0);

    // R1 odd count of ones -> bit 36 and 63
    rsp_valid = 1; rsp_code = 3'b001; rsp_par = 0; tick("R1 odd");
    chk("R1 bit36", rd_data, (64'd1 << 36) | (64'd1 << 63));
    sw_clear_all = 1; tick("R8 clear");
    rsp_valid = 1; rsp_code = 3'b011; rsp_par = 0; tick("R1 even");
    chk("R1 even none", rd_data, 64'd0);
    rsp_valid = 1; rsp_code = 3'b110; rsp_par = 1; tick("R1 odd with pin");
    chk("R1 pin", rd_data[36], 1'b1);
    sw_clear_all = 1; tick("R8 clear");

    // R11 code ignored without valid
    rsp_valid = 0; rsp_code = 3'b111; rsp_par = 0; tick("R11 idle");
    chk("R11 no effect", rd_data, 64'd0);

    // R2, R7
    addr_par_err = 1; tick("R2 addr");
    chk("R2 bit37 R7 valid", rd_data, (64'd1 << 37) | (64'd1 << 63));

    // R5 write clears 37 and 63; write all ones
    sw_wr_en = 1; sw_wr_data = 64'd0; tick("R5 clear by write");
    chk("R5 zeros", rd_data, 64'd0);
    sw_wr_en = 1; sw_wr_data = '1; tick("R5 ones");
    chk("R5 ones written", rd_data, M_WR);
    chk("R6 reserved zero", rd_data & M_RSV, 64'd0);
    sw_clear_all = 1; tick("R8 clear");

    // R3 and R4 sticky
    wdog_timeout = 1; tick("R3 wdog");
    chk("R3 bit38", rd_data, (64'd1 << 38) | (64'd1 << 63));
    hard_err_rsp = 1; tick("R3 hard");
    int_err = 1; tick("R3 ierr");
    chk("R3 all fatal", rd_data & M_STICKY, M_STICKY);
    sw_wr_en = 1; sw_wr_data = 64'd0; tick("R4 write zero");
    chk("R4 sticky held", rd_data, M_STICKY);
    sw_wr_en = 1; sw_wr_data = '1; tick("R4 write ones");
    chk("R4 sticky with ones", rd_data, M_STICKY | M_WR);

    // R8 clear wins over same-cycle events and write
    sw_clear_all = 1; int_err = 1; addr_par_err = 1; sw_wr_en = 1; sw_wr_data = '1;
    tick("R8 priority");
    chk("R8 all zero", rd_data, 64'd0);

    // R9 event beats write of zero
    sw_wr_en = 1; sw_wr_data = 64'd0; addr_par_err = 1; tick("R9 collide");
    chk("R9 event wins", rd_data, (64'd1 << 37) | (64'd1 << 63));
    sw_clear_all = 1; tick("R8 clear");

    // Constrained random
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      rsp_valid    = ($urandom_range(0, 3) == 0);
      rsp_code     = 3'($urandom);
      rsp_par      = 1'($urandom);
      addr_par_err = ($urandom_range(0, 15) == 0);
      wdog_timeout = ($urandom_range(0, 63) == 0);
      hard_err_rsp = ($urandom_range(0, 63) == 0);
      int_err      = ($urandom_range(0, 63) == 0);
      sw_wr_en     = ($urandom_range(0, 7) == 0);
      sw_wr_data   = {$urandom, $urandom};
      sw_clear_all = ($urandom_range(0, 99) == 0);
      tick("R5 random model");
    end

    // R10 reset mid-run
    wdog_timeout = 1; tick("R3 pre-reset");
    rst = 1'b1; @(posedge clk); #2 rst = 1'b0; exp_q = 64'd0;
    chk("R10 reset clears", rd_data, 64'd0);

    finish_run();
  end
endmodule